// File: doc/BRIEF.md
# Instruction Fetch Memory Protection Unit

This block sits between the processor's instruction fetch port and the system bus. Every fetch request carries an address and a privilege flag. The unit compares the address with a set of programmable protection regions, and with a default global region that covers all other addresses. It then decides whether the fetch may execute at that privilege level. An allowed fetch goes to the bus side one cycle later with its address unchanged. A denied fetch is dropped, the fault is recorded and an interrupt request to the processor is raised.

Each region has a base address, a power-of-two size, an enable bit and two execute permissions, one for supervisor and one for user. Regions may overlap. When they do, the region with the lowest index decides. Software programs the regions through a register port, reads back the fault status, and acknowledges the interrupt through the same port.

Top module: `ifmpu`

## Requirements
- R1: After reset, every programmable region is disabled. The global region allows supervisor execution and denies user execution, so a supervisor fetch is forwarded and a user fetch is blocked.
- R2: Register map (word offsets, N regions). Offset 2i holds the base of region i, with bits 31:12 stored and bits 11:0 reading zero. Offset 2i+1 holds the attributes of region i: bit0 enable, bit1 supervisor execute, bit2 user execute, bits 12:8 size code. Offset 2N holds the global attributes (bit1 supervisor execute, bit2 user execute). Offset 2N+1 holds the status (bit0 pending, bit1 global decided, bits 4 and up region index). Offset 2N+2 holds the fault address. Unused bits read zero.
- R3: A size code c from 12 to 31 selects a region of 2^c bytes, and only address bits 31:c are compared with the base. A code below 12 selects the whole 4 GB space.
- R4: When several enabled regions match a fetch, the one with the lowest index supplies the permissions and is reported in the status.
- R5: When no enabled region matches, the global region's permissions apply.
- R6: A supervisor fetch (priv=1) needs supervisor execute and a user fetch (priv=0) needs user execute. An allowed fetch asserts bus_valid_o for exactly one cycle, on the clock edge that accepts it.
- R7: The forwarded address equals the fetch address bit for bit.
- R8: A denied fetch does not assert bus_valid_o. On the same edge, irq_o rises and the status latches the fault address, plus either the deciding region index or the global flag.
- R9: irq_o stays high until software writes 1 to status bit0. While a fault is pending, later faults do not overwrite the recorded address or region.
- R10: A region whose enable bit is clear never matches, whatever its base, size and permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Fetch request present this cycle |
| fetch_addr_i | input | 32 | Fetch address |
| fetch_priv_i | input | 1 | 1 = supervisor, 0 = user |
| bus_valid_o | output | 1 | Forwarded fetch valid |
| bus_addr_o | output | 32 | Forwarded fetch address |
| irq_o | output | 1 | Protection violation interrupt request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data (combinational) |

## Verification
The hardest case to reach from the ports is a fetch that falls inside two enabled, overlapping regions whose permissions disagree. The bench builds this by nesting a small supervisor-only region inside a larger region that allows both privilege levels. A user fetch in the shared part must fault and report index 0, and a user fetch just past the small region must pass. A second fault raised while the first is still pending shows that the recorded fault is kept. Size codes at both limits, 12 and below 12, are checked at the exact boundary addresses.

// File: rtl/ifmpu_pkg.sv
package ifmpu_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned CODE_W   = 5;

  typedef struct packed {
    logic                        en;
    logic                        sx;
    logic                        ux;
    logic [CODE_W-1:0]           size_code;
    logic [ADDR_W-1:PAGE_LSB]    base;
  } region_cfg_t;
endpackage

// File: rtl/ifmpu_regs.sv
module ifmpu_regs
  import ifmpu_pkg::*;
#(
  parameter int unsigned N_REG = 4,
  parameter int unsigned AW    = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [AW-1:0]          cfg_addr_i,
  input  logic [31:0]            cfg_wdata_i,
  output logic [31:0]            cfg_rdata_o,
  output region_cfg_t [N_REG-1:0] regions_o,
  output logic                   glb_sx_o,
  output logic                   glb_ux_o,
  input  logic                   fault_i,
  input  logic [ADDR_W-1:0]      fault_addr_i,
  input  logic                   fault_glb_i,
  input  logic [IDX_W-1:0]       fault_idx_i,
  output logic                   irq_o
);
  localparam logic [AW-1:0] OFS_GLB  = AW'(2 * N_REG);
  localparam logic [AW-1:0] OFS_STAT = AW'(2 * N_REG + 1);
  localparam logic [AW-1:0] OFS_FADR = AW'(2 * N_REG + 2);

  region_cfg_t [N_REG-1:0] reg_q;
  logic                    glb_sx_q, glb_ux_q;
  logic                    pend_q, fglb_q;
  logic [IDX_W-1:0]        fidx_q;
  logic [ADDR_W-1:0]       faddr_q;
  logic                    clr;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    localparam logic [AW-1:0] OFS_BASE = AW'(2 * i);
    localparam logic [AW-1:0] OFS_ATTR = AW'(2 * i + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q[i] <= '0;
      end else if (cfg_we_i) begin
        if (cfg_addr_i == OFS_BASE) reg_q[i].base <= cfg_wdata_i[ADDR_W-1:PAGE_LSB];
        if (cfg_addr_i == OFS_ATTR) begin
          reg_q[i].en        <= cfg_wdata_i[0];
          reg_q[i].sx        <= cfg_wdata_i[1];
          reg_q[i].ux        <= cfg_wdata_i[2];
          reg_q[i].size_code <= cfg_wdata_i[8 +: CODE_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_sx_q <= 1'b1;
      glb_ux_q <= 1'b0;
    end else if (cfg_we_i && cfg_addr_i == OFS_GLB) begin
      glb_sx_q <= cfg_wdata_i[1];
      glb_ux_q <= cfg_wdata_i[2];
    end
  end

  assign clr = cfg_we_i && (cfg_addr_i == OFS_STAT) && cfg_wdata_i[0];

  // first fault wins while pending; a clear in the same cycle admits the new one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      fglb_q  <= 1'b0;
      fidx_q  <= '0;
      faddr_q <= '0;
    end else if (fault_i && (!pend_q || clr)) begin
      pend_q  <= 1'b1;
      fglb_q  <= fault_glb_i;
      fidx_q  <= fault_idx_i;
      faddr_q <= fault_addr_i;
    end else if (clr) begin
      pend_q  <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (cfg_addr_i == AW'(2 * i))
        cfg_rdata_o[ADDR_W-1:PAGE_LSB] = reg_q[i].base;
      if (cfg_addr_i == AW'(2 * i + 1)) begin
        cfg_rdata_o[0]             = reg_q[i].en;
        cfg_rdata_o[1]             = reg_q[i].sx;
        cfg_rdata_o[2]             = reg_q[i].ux;
        cfg_rdata_o[8 +: CODE_W]   = reg_q[i].size_code;
      end
    end
    if (cfg_addr_i == OFS_GLB) begin
      cfg_rdata_o[1] = glb_sx_q;
      cfg_rdata_o[2] = glb_ux_q;
    end
    if (cfg_addr_i == OFS_STAT) begin
      cfg_rdata_o[0]          = pend_q;
      cfg_rdata_o[1]          = fglb_q;
      cfg_rdata_o[4 +: IDX_W] = fidx_q;
    end
    if (cfg_addr_i == OFS_FADR) cfg_rdata_o = faddr_q;
  end

  assign regions_o = reg_q;
  assign glb_sx_o  = glb_sx_q;
  assign glb_ux_o  = glb_ux_q;
  assign irq_o     = pend_q;

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr) |=> pend_q); // R9
  AST_FIRST_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr) |=> ($stable(faddr_q) && $stable(fidx_q) && $stable(fglb_q))); // R9
endmodule

// File: rtl/ifmpu_region_match.sv
module ifmpu_region_match
  import ifmpu_pkg::*;
(
  input  region_cfg_t       cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [5:0]                  eff_exp;
  logic [ADDR_W-1:PAGE_LSB]    mask;

  // codes below the page size select the whole address space
  assign eff_exp = (cfg_i.size_code < CODE_W'(PAGE_LSB)) ? 6'd32 : {1'b0, cfg_i.size_code};

  always_comb begin
    for (int k = PAGE_LSB; k < ADDR_W; k++) mask[k] = (6'(k) >= eff_exp);
  end

  assign hit_o = cfg_i.en && (((addr_i[ADDR_W-1:PAGE_LSB] ^ cfg_i.base) & mask) == '0);
endmodule

// File: rtl/ifmpu_decide.sv
module ifmpu_decide
  import ifmpu_pkg::*;
#(
  parameter int unsigned N_REG = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REG-1:0]        hit_i,
  input  region_cfg_t [N_REG-1:0] regions_i,
  input  logic                    glb_sx_i,
  input  logic                    glb_ux_i,
  input  logic                    priv_i,
  output logic                    allow_o,
  output logic                    glb_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [N_REG-1:0] sel_oh;
  logic             sx, ux;

  assign sel_oh = hit_i & ~(hit_i - N_REG'(1));

  always_comb begin
    idx_o = '0;
    for (int i = N_REG - 1; i >= 0; i--) if (hit_i[i]) idx_o = IDX_W'(i);
  end

  assign glb_o   = (hit_i == '0);
  assign sx      = glb_o ? glb_sx_i : regions_i[idx_o].sx;
  assign ux      = glb_o ? glb_ux_i : regions_i[idx_o].ux;
  assign allow_o = priv_i ? sx : ux;

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_oh)); // R4
  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_o) |-> sel_oh[idx_o]); // R4
endmodule

// File: rtl/ifmpu.sv
module ifmpu
  import ifmpu_pkg::*;
#(
  parameter int unsigned N_REG = 4,
  parameter int unsigned IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1,
  parameter int unsigned AW    = $clog2(2 * N_REG + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_priv_i,
  output logic              bus_valid_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              irq_o,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o
);
  region_cfg_t [N_REG-1:0] regions;
  logic                    glb_sx, glb_ux;
  logic [N_REG-1:0]        hit;
  logic                    allow, dec_glb, fault;
  logic [IDX_W-1:0]        dec_idx;

  ifmpu_regs #(.N_REG(N_REG), .AW(AW), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .regions_o   (regions),
    .glb_sx_o    (glb_sx),
    .glb_ux_o    (glb_ux),
    .fault_i     (fault),
    .fault_addr_i(fetch_addr_i),
    .fault_glb_i (dec_glb),
    .fault_idx_i (dec_idx),
    .irq_o
  );

  for (genvar i = 0; i < N_REG; i++) begin : g_match
    ifmpu_region_match u_match (
      .cfg_i (regions[i]),
      .addr_i(fetch_addr_i),
      .hit_o (hit[i])
    );
    AST_DISABLED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !regions[i].en |-> !hit[i]); // R10
  end

  ifmpu_decide #(.N_REG(N_REG), .IDX_W(IDX_W)) u_decide (
    .clk_i, .rst_ni,
    .hit_i    (hit),
    .regions_i(regions),
    .glb_sx_i (glb_sx),
    .glb_ux_i (glb_ux),
    .priv_i   (fetch_priv_i),
    .allow_o  (allow),
    .glb_o    (dec_glb),
    .idx_o    (dec_idx)
  );

  assign fault = fetch_valid_i && !allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_valid_o <= 1'b0;
      bus_addr_o  <= '0;
    end else begin
      bus_valid_o <= fetch_valid_i && allow;
      if (fetch_valid_i) bus_addr_o <= fetch_addr_i;
    end
  end

  AST_ADDR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (bus_addr_o == $past(fetch_addr_i))); // R7
  AST_FWD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> $past(fetch_valid_i)); // R6
  AST_BLOCK_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fetch_valid_i) && !bus_valid_o) |-> irq_o); // R8
endmodule

// File: tb/ifmpu_test.sv
`timescale 1ns/1ps
module ifmpu_test;
  localparam logic [3:0] O_GLB = 4'd8, O_STAT = 4'd9, O_FADR = 4'd10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_priv = 1'b0;
  logic        bus_valid, irq;
  logic [31:0] bus_addr;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ifmpu uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr), .fetch_priv_i(fetch_priv),
    .bus_valid_o(bus_valid), .bus_addr_o(bus_addr), .irq_o(irq),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  // one fetch; outputs sampled at the next falling edge, after the accepting edge
  task automatic fetch(input logic [31:0] a, input bit priv, input bit exp_ok, input string req);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; fetch_priv = priv;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(bus_valid == exp_ok, req, {31'd0, bus_valid}, {31'd0, exp_ok});
    if (exp_ok) chk(bus_addr == a, "R7", bus_addr, a);
    else        chk(irq == 1'b1, req, {31'd0, irq}, 32'd1);
  endtask

  task automatic clear_irq();
    wr(O_STAT, 32'h1);
    chk(irq == 1'b0, "R9", {31'd0, irq}, 32'd0);
  endtask

  task automatic wipe();
    for (int i = 0; i < 4; i++) wr(4'(2 * i + 1), 32'h0);
    wr(O_GLB, 32'h2);
    wr(O_STAT, 32'h1);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) rd_chk(4'(2 * i + 1), 32'h0, "R1");
    rd_chk(O_GLB, 32'h2, "R1");
    rd_chk(O_STAT, 32'h0, "R1");
    chk(irq == 1'b0 && bus_valid == 1'b0, "R1", {30'd0, irq, bus_valid}, 32'd0);
    fetch(32'h0000_0100, 1'b1, 1'b1, "R1");
    @(negedge clk);
    chk(bus_valid == 1'b0, "R6", {31'd0, bus_valid}, 32'd0);
    fetch(32'h0000_0200, 1'b0, 1'b0, "R1");
    rd_chk(O_STAT, 32'h3, "R8");
    rd_chk(O_FADR, 32'h0000_0200, "R8");
    clear_irq();
  endtask

  task automatic t_regmap();
    wr(4'd2, 32'h1234_5FFF);
    rd_chk(4'd2, 32'h1234_5000, "R2");
    wr(4'd3, 32'hFFFF_FFFF);
    rd_chk(4'd3, 32'h0000_1F07, "R2");
    wr(O_GLB, 32'hFFFF_FFFF);
    rd_chk(O_GLB, 32'h0000_0006, "R2");
    wipe();
  endtask

  task automatic t_size();
    wr(4'd0, 32'h0001_0000);
    wr(4'd1, 32'h0000_1007);           // code 16: 64 KB
    fetch(32'h0001_FFFC, 1'b0, 1'b1, "R3");
    fetch(32'h0002_0000, 1'b0, 1'b0, "R3");
    rd_chk(O_STAT, 32'h3, "R5");
    clear_irq();
    wr(4'd1, 32'h0000_0C07);           // code 12: 4 KB
    fetch(32'h0001_0FFC, 1'b0, 1'b1, "R3");
    fetch(32'h0001_1000, 1'b0, 1'b0, "R3");
    clear_irq();
    wr(4'd1, 32'h0000_0507);           // code 5: whole space
    fetch(32'hFFFF_FFF0, 1'b0, 1'b1, "R3");
    fetch(32'h0000_0000, 1'b0, 1'b1, "R3");
    wipe();
  endtask

  task automatic t_priority();
    wr(4'd0, 32'h4000_0000);
    wr(4'd1, 32'h0000_1403);           // 1 MB, supervisor only
    wr(4'd2, 32'h4000_0000);
    wr(4'd3, 32'h0000_1807);           // 16 MB, both
    fetch(32'h4000_0100, 1'b0, 1'b0, "R4");
    rd_chk(O_STAT, 32'h1, "R4");
    clear_irq();
    fetch(32'h4010_0000, 1'b0, 1'b1, "R4");
    fetch(32'h4000_0100, 1'b1, 1'b1, "R6");
    wr(4'd1, 32'h0); wr(4'd3, 32'h0);
    wr(4'd4, 32'h8000_0000);
    wr(4'd5, 32'h0000_0C03);
    fetch(32'h8000_0004, 1'b0, 1'b0, "R8");
    rd_chk(O_STAT, 32'h21, "R8");
    rd_chk(O_FADR, 32'h8000_0004, "R8");
    wipe();
  endtask

  task automatic t_disabled();
    wr(4'd7, 32'h0000_0006);           // whole space, all perms, disabled
    fetch(32'h1234_5678, 1'b0, 1'b0, "R10");
    rd_chk(O_STAT, 32'h3, "R10");
    clear_irq();
    wr(4'd7, 32'h0000_0007);
    fetch(32'h1234_5678, 1'b0, 1'b1, "R10");
    wipe();
  endtask

  task automatic t_perm();
    wr(O_GLB, 32'h4);                  // user only
    fetch(32'h0000_3000, 1'b1, 1'b0, "R6");
    clear_irq();
    fetch(32'hA5A5_5A5C, 1'b0, 1'b1, "R6");
    wipe();
  endtask

  task automatic t_sticky();
    fetch(32'h0000_1111, 1'b0, 1'b0, "R9");
    fetch(32'h0000_2222, 1'b0, 1'b0, "R9");
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R9", {31'd0, irq}, 32'd1);
    rd_chk(O_FADR, 32'h0000_1111, "R9");
    clear_irq();
    fetch(32'h0000_3333, 1'b0, 1'b0, "R9");
    rd_chk(O_FADR, 32'h0000_3333, "R9");
    clear_irq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_size();
    t_priority();
    t_disabled();
    t_perm();
    t_sticky();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule